// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

The block turns a step clock into the drive pattern for the two H-bridges of a two-phase bipolar stepper motor. An eight-position state machine walks a fixed rotation of coil-current combinations. Every rising edge on the step input moves it one position in half-step mode or two positions in full-step mode. A direction input chooses clockwise, which counts up, or counterclockwise, which counts down. For each bridge the block gives an enable bit and a polarity bit. Current chopping and reference generation are left to the power stage.

The step input is asynchronous to the system clock. It passes through a multi-flop synchroniser and a rising-edge detector, so only one advance is made for each pulse however long the pulse lasts. The reset input is active low and asserts asynchronously. Its release is synchronised, and it always returns the machine to the home position, where both coils are driven positive. Full-step mode adds two to the position and so keeps its parity. Selecting full step while the position is odd gives two-phase-on drive. Selecting it while the position is even gives one-phase-on (wave) drive. The usual way to reach wave drive is to make one half step from home and then change to full step.

The direction and mode inputs are expected to be steady for at least 1 µs on either side of a step edge, with at most 100 kHz stepping. For this reason they are sampled directly on the cycle the step edge is detected.

Top module: `stepper_phase_seq`

## Requirements
- R1: While reset is low, and after it is released before any step, the outputs show the home position: {a_en,a_pos,b_en,b_pos} = 4'b1111.
- R2: In half-step mode (half_mode=1) with dir_cw=1, successive steps visit positions 1,2,3,4,5,6,7,8 and then wrap to 1.
- R3: In half-step mode with dir_cw=0, successive steps from home visit positions 8,7,6,… (count down modulo 8).
- R4: In full-step mode (half_mode=0) from an odd position, each step moves two positions in the selected direction, and both bridges remain enabled (1,3,5,7 or 1,7,5,3).
- R5: In full-step mode from an even position, each step moves two positions, and exactly one bridge is enabled at each position (2,4,6,8 or 8,6,4,2).
- R6: Exactly one advance happens for each rising edge of step_in. A step level held high or low causes no further change.
- R7: The output encoding {a_en,a_pos,b_en,b_pos} for positions 1..8 is 1111, 0011, 1011, 1000, 1010, 0010, 1110, 1100. A disabled bridge always shows polarity 0, and the two bridges are never disabled together.
- R8: A step input that is already high when reset is released is not counted as a step.
- R9: Asserting reset in the middle of a run returns the outputs to the home position, whatever the current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| step_in | input | 1 | Asynchronous step clock; each rising edge advances the sequence |
| dir_cw | input | 1 | 1 = clockwise (count up), 0 = counterclockwise (count down) |
| half_mode | input | 1 | 1 = half-step, 0 = full-step |
| pha_en | output | 1 | Bridge A enable |
| pha_pos | output | 1 | Bridge A polarity, 1 = positive current |
| phb_en | output | 1 | Bridge B enable |
| phb_pos | output | 1 | Bridge B polarity, 1 = positive current |

## Verification
The bench wraps past position 8 in both directions. A design with an off-by-one modulo would stall at 8 or skip from 8 to 2. It enters wave drive by making one half step and then changing to full step. A design that forced full steps onto odd positions would re-energise both coils there. It holds the step level high for many cycles, where a level-sensitive design would keep advancing. It also releases reset with the step input already high, where a badly initialised edge detector would make a phantom first step.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  localparam int unsigned NUM_POS = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_POS);

  typedef logic [IDX_W-1:0] pos_idx_t;

  localparam pos_idx_t HOME_POS = '0;

  typedef struct packed {
    logic a_en;
    logic a_pos;
    logic b_en;
    logic b_pos;
  } bridge_drive_t;

  // Index k = position - 1. Odd indices are one-coil positions.
  function automatic bridge_drive_t drive_of(pos_idx_t k);
    bridge_drive_t d;
    d.a_en  = (k[1:0] != 2'b01);
    d.b_en  = (k[1:0] != 2'b11);
    d.a_pos = d.a_en && ((k == pos_idx_t'(0)) || (k >= pos_idx_t'(6)));
    d.b_pos = d.b_en && (k <= pos_idx_t'(2));
    return d;
  endfunction

endpackage

// File: rtl/stepseq_rst_sync.sv
module stepseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/stepseq_edge.sv
module stepseq_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_async,
  output logic step_evt
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // Shift chain, written stage by stage.
  assign sync_d[0] = step_async;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  // Reset to ones: a level already high at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign step_evt = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stepseq_fsm.sv
module stepseq_fsm
  import stepseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step_evt,
  input  logic     dir_cw,
  input  logic     half_mode,
  output pos_idx_t pos_q
);
  pos_idx_t delta;
  pos_idx_t pos_d;

  always_comb begin
    delta = half_mode ? pos_idx_t'(1) : pos_idx_t'(2);
    pos_d = pos_q;
    if (step_evt) begin
      if (dir_cw) pos_d = pos_q + delta;
      else        pos_d = pos_q - delta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= HOME_POS;
    else if (step_evt) pos_q <= pos_d;
  end
endmodule

// File: rtl/stepseq_decode.sv
module stepseq_decode
  import stepseq_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pos_idx_t      pos,
  output bridge_drive_t drive
);
  bridge_drive_t drive_d;

  always_comb drive_d = drive_of(pos);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive <= drive_of(HOME_POS);
      else        drive <= drive_d;
    end
  end else begin : g_comb
    assign drive = drive_d;
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter bit          OUT_REG     = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic step_in,
  input  logic dir_cw,
  input  logic half_mode,
  output logic pha_en,
  output logic pha_pos,
  output logic phb_en,
  output logic phb_pos
);
  logic          rst_sync_n;
  logic          step_evt;
  pos_idx_t      state_q;
  bridge_drive_t drive;

  stepseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_sync_n (rst_sync_n)
  );

  stepseq_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_async (step_in),
    .step_evt   (step_evt)
  );

  stepseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_evt  (step_evt),
    .dir_cw    (dir_cw),
    .half_mode (half_mode),
    .pos_q     (state_q)
  );

  stepseq_decode #(.OUT_REG(OUT_REG)) u_dec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pos   (state_q),
    .drive (drive)
  );

  assign pha_en  = drive.a_en;
  assign pha_pos = drive.a_pos;
  assign phb_en  = drive.b_en;
  assign phb_pos = drive.b_pos;
endmodule

// File: rtl/stepseq_chk.sv
module stepseq_chk
  import stepseq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     step_evt,
  input logic     half_mode,
  input pos_idx_t state_q,
  input logic     pha_en,
  input logic     pha_pos,
  input logic     phb_en,
  input logic     phb_pos
);
  assert_one_bridge_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pha_en || phb_en);

  assert_off_a_no_pol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pha_en |-> !pha_pos);

  assert_off_b_no_pol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !phb_en |-> !phb_pos);

  assert_hold_without_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(state_q));

  assert_single_cycle_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> !step_evt);

  assert_half_flips_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && half_mode) |=> (state_q[0] != $past(state_q[0])));

  assert_full_keeps_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !half_mode) |=> (state_q[0] == $past(state_q[0])));
endmodule

bind stepper_phase_seq stepseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .step_evt  (step_evt),
  .half_mode (half_mode),
  .state_q   (state_q),
  .pha_en    (pha_en),
  .pha_pos   (pha_pos),
  .phb_en    (phb_en),
  .phb_pos   (phb_pos)
);

// File: tb/sim_stepper_phase_seq.sv
`timescale 1ns/1ps
module sim_stepper_phase_seq;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic step_in = 1'b0;
  logic dir_cw = 1'b1;
  logic half_mode = 1'b1;
  logic pha_en, pha_pos, phb_en, phb_pos;

  int checks = 0;
  int errors = 0;
  int model_pos = 1;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  event       push_ev;

  always #2.5 clk = ~clk;

  stepper_phase_seq u0 (
    .clk(clk), .arst_n(arst_n), .step_in(step_in), .dir_cw(dir_cw),
    .half_mode(half_mode), .pha_en(pha_en), .pha_pos(pha_pos),
    .phb_en(phb_en), .phb_pos(phb_pos)
  );

  // Encoding from R7, positions 1..8.
  function automatic logic [3:0] enc(int p);
    case (p)
      1: enc = 4'b1111;
      2: enc = 4'b0011;
      3: enc = 4'b1011;
      4: enc = 4'b1000;
      5: enc = 4'b1010;
      6: enc = 4'b0010;
      7: enc = 4'b1110;
      default: enc = 4'b1100;
    endcase
  endfunction

  task automatic expect_now(string tag);
    exp_q.push_back(enc(model_pos));
    tag_q.push_back(tag);
    -> push_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_step(string tag, int hold_hi);
    int d;
    @(negedge clk);
    step_in = 1'b1;
    repeat (hold_hi) @(negedge clk);
    step_in = 1'b0;
    repeat (8) @(negedge clk);
    d = half_mode ? 1 : 2;
    model_pos = dir_cw ? ((model_pos - 1 + d) % 8) + 1
                       : ((model_pos - 1 + 8 - d) % 8) + 1;
    expect_now(tag);
  endtask

  task automatic do_reset(bit step_level);
    @(negedge clk);
    step_in = step_level;
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_pos = 1;
    expect_now("R1 reset held");
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: pops expected values and compares with the outputs.
  initial begin
    forever begin
      @(push_ev);
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [3:0] e;
        logic [3:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {pha_en, pha_pos, phb_en, phb_pos};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    expect_now("R1 after release");

    // R2: half step clockwise with wrap
    half_mode = 1'b1; dir_cw = 1'b1;
    for (int i = 0; i < 9; i++) do_step("R2 half cw / R7 encoding", 3);

    // R9: reset mid-run at a non-home position
    do_step("R2 half cw", 3);
    do_reset(1'b0);
    expect_now("R9 home after mid-run reset");

    // R3: half step counterclockwise
    dir_cw = 1'b0;
    for (int i = 0; i < 3; i++) do_step("R3 half ccw", 3);

    // R4: full step normal drive from home
    do_reset(1'b0);
    half_mode = 1'b0; dir_cw = 1'b1;
    for (int i = 0; i < 5; i++) do_step("R4 full cw normal", 3);
    dir_cw = 1'b0;
    for (int i = 0; i < 2; i++) do_step("R4 full ccw normal", 3);

    // R5: wave drive: one half step, then full step
    do_reset(1'b0);
    half_mode = 1'b1; dir_cw = 1'b1;
    do_step("R5 entry half step", 3);
    half_mode = 1'b0;
    for (int i = 0; i < 4; i++) do_step("R5 full cw wave", 3);
    dir_cw = 1'b0;
    for (int i = 0; i < 2; i++) do_step("R5 full ccw wave", 3);

    // R6: long high level counts once
    half_mode = 1'b1; dir_cw = 1'b1;
    @(negedge clk);
    step_in = 1'b1;
    repeat (10) @(negedge clk);
    model_pos = (model_pos % 8) + 1;
    expect_now("R6 one advance per edge");
    repeat (30) @(negedge clk);
    expect_now("R6 held high no further advance");
    step_in = 1'b0;
    repeat (30) @(negedge clk);
    expect_now("R6 held low no advance");

    // R8: step high across reset release
    do_reset(1'b1);
    expect_now("R8 no phantom step");
    step_in = 1'b0;
    repeat (6) @(negedge clk);
    expect_now("R8 falling level no step");
    do_step("R8 first real step", 3);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule